// File: doc/BRIEF.md
# Split-Protection Data Cache

This block is a level-one data cache built from two direct-mapped arrays that sit side by side between the processor and memory. A large array stores plain 32-bit words. A small array stores every word together with a seven-bit single-error-correct, double-error-detect code. A table holding one bit per 1 KB page steers each processor load or store to exactly one of the two arrays. Data that must survive upsets goes to the protected array, and bulk data that can tolerate them stays in the cheaper one.

Software sets the page bits through a small configuration port while the cache is idle. The processor side takes one word request at a time and answers with a one-cycle response pulse. The memory side moves whole 16-byte lines: a line write for a dirty victim, then a line read for the fill. Both arrays are write-back and write-allocate. Protected reads correct single-bit errors, write the repaired word back, and flag double-bit errors on the response.

Top module: `ppc_cache`

## Requirements
- R1: After reset, `cpu_req_ready` is 1, `cpu_resp_valid` is 0 and `mem_req` is 0.
- R2: A load to an unprotected page (page bit 0) returns the memory word. In a fill line, the word at the lowest address is in bits [31:0]. A hit responds on the cycle after acceptance. `cpu_req_ready` is low in the cycle after acceptance.
- R3: A store allocates its line on a miss. A later load returns the stored value. A store or load hit makes no memory request.
- R4: In the unprotected array the line index is address bits [10:4]. A miss on a dirty line first writes the victim line to its own address, then reads the new line. A clean victim is replaced without a write. `mem_req`, `mem_we` and `mem_addr` hold until `mem_ack`.
- R5: A configuration write while idle sets the bit of page `cfg_page` (address bits [15:10]). Accesses to a page with the bit set use the protected array and respond two cycles after acceptance. Its line index is address bits [7:4], so addresses A and A+256 evict each other.
- R6: In the unprotected array, addresses A and A+256 occupy different lines and both stay resident.
- R7: A protected word is stored as {p, c[5:0], d[31:0]}. The data bits occupy the Hamming positions 3..38 that are not powers of two, in ascending order. c[i] is the XOR of the data bits whose position has bit i set, and p is the XOR of all 38 other bits. Any single flipped bit is corrected on a load, with `cpu_resp_uncorr` 0.
- R8: Two flipped bits in a protected word raise `cpu_resp_uncorr`, and only together with `cpu_resp_valid`.
- R9: A configuration write while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_we | input | 1 | 1 for store, 0 for load |
| cpu_req_addr | input | ADDR_W | Byte address, word aligned |
| cpu_req_wdata | input | 32 | Store data |
| cpu_resp_valid | output | 1 | One-cycle response pulse |
| cpu_resp_rdata | output | 32 | Load data (0 for stores) |
| cpu_resp_uncorr | output | 1 | Uncorrectable error on a protected load |
| cfg_we | input | 1 | Page table write strobe |
| cfg_page | input | ADDR_W-PAGE_LG | Page number to write |
| cfg_prot | input | 1 | 1 routes the page to the protected array |
| mem_req | output | 1 | Line transfer request, held until acknowledged |
| mem_we | output | 1 | 1 for a line write, 0 for a line read |
| mem_addr | output | ADDR_W | Line-aligned address |
| mem_wline | output | LINE_B*8 | Victim line data |
| mem_ack | input | 1 | Memory completes the transfer |
| mem_rline | input | LINE_B*8 | Fill data, valid with mem_ack |

## Verification
A request is accepted at the edge where valid and ready are both high. An unprotected hit responds one cycle later. A protected hit responds two cycles later, because the codeword is captured and then decoded. A miss adds the memory transfers, after which the lookup runs again. The bench drives inputs at the falling edge. It counts falling edges from acceptance until the response pulse and checks that count only for hits. For misses it checks the data and the number of line reads and writes the memory model saw during that one request. Error cases override the protected read word for exactly one request, from before acceptance until its response.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_PDEC,
      ST_WB,
      ST_FILL
   } ppc_state_e;

   // six Hamming check bits; data bit j sits at the j-th non-power-of-two position from 3
   function automatic logic [5:0] ecc_hamm(input logic [31:0] d);
      logic [5:0] c;
      int p;
      c = '0;
      p = 3;
      for (int j = 0; j < 32; j++) begin
         if ((p & (p - 1)) == 0) p = p + 1;
         for (int i = 0; i < 6; i++)
            if (p[i]) c[i] = c[i] ^ d[j];
         p = p + 1;
      end
      return c;
   endfunction

   // seven stored check bits: overall parity on top
   function automatic logic [6:0] ecc_gen(input logic [31:0] d);
      logic [5:0] c;
      c = ecc_hamm(d);
      return {^{d, c}, c};
   endfunction

   // flip the data bit whose position equals the syndrome
   function automatic logic [31:0] ecc_fix(input logic [31:0] d, input logic [5:0] syn);
      logic [31:0] r;
      int p;
      r = d;
      p = 3;
      for (int j = 0; j < 32; j++) begin
         if ((p & (p - 1)) == 0) p = p + 1;
         if (p[5:0] == syn) r[j] = ~r[j];
         p = p + 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/ppc_page_map.sv
module ppc_page_map #(
   parameter int PG_W = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic [PG_W-1:0] wr_page,
   input  logic            wr_prot,
   input  logic [PG_W-1:0] rd_page,
   output logic            rd_prot
);
   localparam int PAGES = 1 << PG_W;

   logic [PAGES-1:0] prot_q;

   always_ff @(posedge clk) begin
      if (rst) prot_q <= '0;
      else if (wr_en) prot_q[wr_page] <= wr_prot;
   end

   assign rd_prot = prot_q[rd_page];
endmodule

// File: rtl/ppc_secded_dec.sv
module ppc_secded_dec (
   input  logic [38:0] cw,
   output logic [31:0] data,
   output logic        corr,
   output logic        dbl
);
   logic [5:0] syn;
   logic       par;

   assign syn  = ppc_pkg::ecc_hamm(cw[31:0]) ^ cw[37:32];
   assign par  = ^cw;
   assign corr = par;
   assign dbl  = !par && (syn != 6'd0);
   assign data = (par && syn != 6'd0) ? ppc_pkg::ecc_fix(cw[31:0], syn) : cw[31:0];
endmodule

// File: rtl/ppc_array.sv
module ppc_array #(
   parameter int ADDR_W = 16,
   parameter int LINES  = 128,
   parameter int LINE_B = 16,
   parameter bit PROT   = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [ADDR_W-1:0]   lk_addr,
   output logic                hit,
   output logic                vic_dirty,
   output logic [ADDR_W-1:0]   vic_addr,
   output logic [(PROT ? 39 : 32)-1:0] rd_cw,
   output logic [LINE_B*8-1:0] vic_line,
   input  logic                wr_en,
   input  logic                wr_dirty,
   input  logic [31:0]         wr_data,
   input  logic                fill_en,
   input  logic [LINE_B*8-1:0] fill_line
);
   localparam int SW    = PROT ? 39 : 32;
   localparam int OFF_W = $clog2(LINE_B);
   localparam int WPL   = LINE_B / 4;
   localparam int WS_W  = (WPL > 1) ? $clog2(WPL) : 1;
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

   if ((1 << IDX_W) != LINES) begin : g_bad_lines
      $error("ppc_array: LINES must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ppc_array: address too narrow for this array");
   end

   logic [SW-1:0]    store [LINES][WPL];
   logic [TAG_W-1:0] tags  [LINES];
   logic [LINES-1:0] vld, drt;
   logic [SW-1:0]    wr_cw;
   logic [SW-1:0]    fill_cw [WPL];

   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag;
   logic [WS_W-1:0]  ws;
   logic             unused_lo;

   assign idx       = lk_addr[OFF_W +: IDX_W];
   assign tag       = lk_addr[ADDR_W-1 -: TAG_W];
   assign ws        = (WPL > 1) ? lk_addr[2 +: WS_W] : '0;
   assign unused_lo = ^lk_addr[1:0];

   if (PROT) begin : g_ecc
      always_comb begin
         wr_cw = {ppc_pkg::ecc_gen(wr_data), wr_data};
         for (int w = 0; w < WPL; w++)
            fill_cw[w] = {ppc_pkg::ecc_gen(fill_line[w*32 +: 32]), fill_line[w*32 +: 32]};
      end
   end else begin : g_raw
      always_comb begin
         wr_cw = wr_data;
         for (int w = 0; w < WPL; w++)
            fill_cw[w] = fill_line[w*32 +: 32];
      end
   end

   assign hit       = vld[idx] && (tags[idx] == tag);
   assign vic_dirty = vld[idx] && drt[idx];
   assign vic_addr  = {tags[idx], idx, {OFF_W{1'b0}}};
   assign rd_cw     = store[idx][ws];

   always_comb begin
      for (int w = 0; w < WPL; w++)
         vic_line[w*32 +: 32] = store[idx][w][31:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld <= '0;
         drt <= '0;
      end else if (fill_en) begin
         vld[idx] <= 1'b1;
         drt[idx] <= 1'b0;
      end else if (wr_en && wr_dirty) begin
         drt[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tags[idx] <= tag;
         for (int w = 0; w < WPL; w++) store[idx][w] <= fill_cw[w];
      end else if (wr_en) begin
         store[idx][ws] <= wr_cw;
      end
   end
endmodule

// File: rtl/ppc_cache.sv
module ppc_cache #(
   parameter int ADDR_W  = 16,
   parameter int PAGE_LG = 10,
   parameter int LINE_B  = 16,
   parameter int UNP_B   = 2048,
   parameter int PROT_B  = 256
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cpu_req_valid,
   output logic                      cpu_req_ready,
   input  logic                      cpu_req_we,
   input  logic [ADDR_W-1:0]         cpu_req_addr,
   input  logic [31:0]               cpu_req_wdata,
   output logic                      cpu_resp_valid,
   output logic [31:0]               cpu_resp_rdata,
   output logic                      cpu_resp_uncorr,
   input  logic                      cfg_we,
   input  logic [ADDR_W-PAGE_LG-1:0] cfg_page,
   input  logic                      cfg_prot,
   output logic                      mem_req,
   output logic                      mem_we,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic [LINE_B*8-1:0]       mem_wline,
   input  logic                      mem_ack,
   input  logic [LINE_B*8-1:0]       mem_rline
);
   import ppc_pkg::*;

   localparam int PG_W    = ADDR_W - PAGE_LG;
   localparam int LW      = LINE_B * 8;
   localparam int OFF_W   = $clog2(LINE_B);
   localparam int U_LINES = UNP_B / LINE_B;
   localparam int P_LINES = PROT_B / LINE_B;

   if (LINE_B < 4 || (1 << OFF_W) != LINE_B) begin : g_bad_line
      $error("ppc_cache: LINE_B must be a power of two of at least 4");
   end
   if (UNP_B % LINE_B != 0 || PROT_B % LINE_B != 0) begin : g_bad_size
      $error("ppc_cache: array sizes must be whole lines");
   end
   if (PAGE_LG >= ADDR_W || PAGE_LG < OFF_W) begin : g_bad_page
      $error("ppc_cache: page size out of range");
   end

   ppc_state_e        st;
   logic              q_we;
   logic [ADDR_W-1:0] q_addr;
   logic [31:0]       q_wdata;
   logic              q_prot;
   logic [38:0]       pcw_q;
   logic [38:0]       pcw_raw;

   logic              u_hit, u_vd, p_hit, p_vd;
   logic [ADDR_W-1:0] u_va, p_va;
   logic [31:0]       u_rd;
   logic [38:0]       p_rd_cw;
   logic [LW-1:0]     u_vl, p_vl;
   logic              sel_hit, sel_vd;
   logic [31:0]       dec_data;
   logic              dec_corr, dec_dbl;
   logic              u_wr, p_wr, u_fill, p_fill;

   ppc_page_map #(.PG_W(PG_W)) u_map (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we && st == ST_IDLE),
      .wr_page (cfg_page),
      .wr_prot (cfg_prot),
      .rd_page (q_addr[ADDR_W-1:PAGE_LG]),
      .rd_prot (q_prot)
   );

   ppc_array #(.ADDR_W(ADDR_W), .LINES(U_LINES), .LINE_B(LINE_B), .PROT(1'b0)) u_unp (
      .clk       (clk),
      .rst       (rst),
      .lk_addr   (q_addr),
      .hit       (u_hit),
      .vic_dirty (u_vd),
      .vic_addr  (u_va),
      .rd_cw     (u_rd),
      .vic_line  (u_vl),
      .wr_en     (u_wr),
      .wr_dirty  (1'b1),
      .wr_data   (q_wdata),
      .fill_en   (u_fill),
      .fill_line (mem_rline)
   );

   ppc_array #(.ADDR_W(ADDR_W), .LINES(P_LINES), .LINE_B(LINE_B), .PROT(1'b1)) u_prot (
      .clk       (clk),
      .rst       (rst),
      .lk_addr   (q_addr),
      .hit       (p_hit),
      .vic_dirty (p_vd),
      .vic_addr  (p_va),
      .rd_cw     (p_rd_cw),
      .vic_line  (p_vl),
      .wr_en     (p_wr),
      .wr_dirty  (q_we),
      .wr_data   (q_we ? q_wdata : dec_data),
      .fill_en   (p_fill),
      .fill_line (mem_rline)
   );

   ppc_secded_dec u_dec (
      .cw   (pcw_q),
      .data (dec_data),
      .corr (dec_corr),
      .dbl  (dec_dbl)
   );

   assign pcw_raw = p_rd_cw;
   assign sel_hit = q_prot ? p_hit : u_hit;
   assign sel_vd  = q_prot ? p_vd  : u_vd;

   assign u_wr   = (st == ST_LOOK) && !q_prot && u_hit && q_we;
   assign p_wr   = (st == ST_PDEC) && (q_we || dec_corr);
   assign u_fill = (st == ST_FILL) && mem_ack && !q_prot;
   assign p_fill = (st == ST_FILL) && mem_ack && q_prot;

   assign cpu_req_ready = (st == ST_IDLE);
   assign mem_req       = (st == ST_WB) || (st == ST_FILL);
   assign mem_we        = (st == ST_WB);
   assign mem_addr      = (st == ST_WB) ? (q_prot ? p_va : u_va)
                                        : {q_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign mem_wline     = q_prot ? p_vl : u_vl;

   always_ff @(posedge clk) begin
      if (rst) begin
         st              <= ST_IDLE;
         q_we            <= 1'b0;
         q_addr          <= '0;
         q_wdata         <= '0;
         pcw_q           <= '0;
         cpu_resp_valid  <= 1'b0;
         cpu_resp_rdata  <= '0;
         cpu_resp_uncorr <= 1'b0;
      end else begin
         cpu_resp_valid  <= 1'b0;
         cpu_resp_uncorr <= 1'b0;
         unique case (st)
            ST_IDLE: if (cpu_req_valid) begin
               q_we    <= cpu_req_we;
               q_addr  <= cpu_req_addr;
               q_wdata <= cpu_req_wdata;
               st      <= ST_LOOK;
            end
            ST_LOOK: begin
               if (sel_hit) begin
                  if (q_prot) begin
                     pcw_q <= pcw_raw;
                     st    <= ST_PDEC;
                  end else begin
                     cpu_resp_valid <= 1'b1;
                     cpu_resp_rdata <= q_we ? 32'd0 : u_rd;
                     st             <= ST_IDLE;
                  end
               end else begin
                  st <= sel_vd ? ST_WB : ST_FILL;
               end
            end
            ST_PDEC: begin
               cpu_resp_valid  <= 1'b1;
               cpu_resp_rdata  <= q_we ? 32'd0 : dec_data;
               cpu_resp_uncorr <= !q_we && dec_dbl;
               st              <= ST_IDLE;
            end
            ST_WB:   if (mem_ack) st <= ST_FILL;
            ST_FILL: if (mem_ack) st <= ST_LOOK;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ppc_cache_chk.sv
module ppc_cache_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_req_valid,
   input logic              cpu_req_ready,
   input logic              cpu_resp_valid,
   input logic              cpu_resp_uncorr,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack
);
   // R2
   accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_req_valid && cpu_req_ready) |=> (!cpu_req_ready && !cpu_resp_valid));

   // R4
   mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

   // R4
   mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> !cpu_req_ready);

   // R8
   uncorr_valid_chk: assert property (@(posedge clk) disable iff (rst)
      cpu_resp_uncorr |-> cpu_resp_valid);
endmodule

bind ppc_cache ppc_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk             (clk),
   .rst             (rst),
   .cpu_req_valid   (cpu_req_valid),
   .cpu_req_ready   (cpu_req_ready),
   .cpu_resp_valid  (cpu_resp_valid),
   .cpu_resp_uncorr (cpu_resp_uncorr),
   .mem_req         (mem_req),
   .mem_we          (mem_we),
   .mem_addr        (mem_addr),
   .mem_ack         (mem_ack)
);

// File: tb/sim_ppc_cache.sv
module sim_ppc_cache;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         cpu_req_valid = 1'b0;
   logic         cpu_req_ready;
   logic         cpu_req_we = 1'b0;
   logic [15:0]  cpu_req_addr = '0;
   logic [31:0]  cpu_req_wdata = '0;
   logic         cpu_resp_valid;
   logic [31:0]  cpu_resp_rdata;
   logic         cpu_resp_uncorr;
   logic         cfg_we = 1'b0;
   logic [5:0]   cfg_page = '0;
   logic         cfg_prot = 1'b0;
   logic         mem_req;
   logic         mem_we;
   logic [15:0]  mem_addr;
   logic [127:0] mem_wline;
   logic         mem_ack = 1'b0;
   logic [127:0] mem_rline = '0;

   always #5 clk = ~clk;

   ppc_cache u0 (.*);

   int          total = 0;
   int          bad = 0;
   int          nfill = 0;
   int          nwb = 0;
   bit          done = 1'b0;
   logic [31:0] bmem [1024];
   logic [31:0] gmem [1024];
   logic [38:0] fcw;

   // entry: {we, addr[15:0], wdata[31:0], line reads[1:0], line writes[1:0]}
   localparam logic [52:0] VEC [13] = '{
      {1'b0, 16'h0010, 32'h0,         2'd1, 2'd0},   // R2 miss
      {1'b0, 16'h0014, 32'h0,         2'd0, 2'd0},   // R2 hit
      {1'b1, 16'h0018, 32'h11112222,  2'd0, 2'd0},   // R3 store hit
      {1'b0, 16'h0018, 32'h0,         2'd0, 2'd0},   // R3 readback
      {1'b0, 16'h0818, 32'h0,         2'd1, 2'd1},   // R4 dirty victim
      {1'b0, 16'h0018, 32'h0,         2'd1, 2'd0},   // R4 clean victim
      {1'b0, 16'h0118, 32'h0,         2'd1, 2'd0},   // R6 A+256
      {1'b0, 16'h0018, 32'h0,         2'd0, 2'd0},   // R6 A still resident
      {1'b1, 16'h0404, 32'hDEADBEEF,  2'd1, 2'd0},   // R5 protected store miss
      {1'b0, 16'h0404, 32'h0,         2'd0, 2'd0},   // R5 protected hit
      {1'b0, 16'h0504, 32'h0,         2'd1, 2'd1},   // R5 A+256 evicts dirty A
      {1'b0, 16'h0404, 32'h0,         2'd1, 2'd0},   // R5 A refilled
      {1'b0, 16'h0C20, 32'h0,         2'd1, 2'd0}    // R2 another page
   };

   function automatic logic [38:0] tb_enc(input logic [31:0] d);
      logic [5:0] c;
      int k;
      c = '0;
      k = 0;
      for (int pos = 1; pos < 39; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            for (int i = 0; i < 6; i++)
               if (((pos >> i) & 1) != 0) c[i] = c[i] ^ d[k];
            k++;
         end
      end
      return {^{d, c}, c, d};
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [15:0] a, input logic [31:0] wd,
                         output logic [31:0] rd, output logic err, output int lat);
      @(negedge clk);
      cpu_req_valid = 1'b1;
      cpu_req_we    = we;
      cpu_req_addr  = a;
      cpu_req_wdata = wd;
      while (!cpu_req_ready) @(negedge clk);
      @(negedge clk);
      cpu_req_valid = 1'b0;
      lat = 0;
      while (!cpu_resp_valid) begin
         @(negedge clk);
         lat++;
      end
      rd  = cpu_resp_rdata;
      err = cpu_resp_uncorr;
      if (we) gmem[a[11:2]] = wd;
   endtask

   task automatic cfg_write(input logic [5:0] pg, input logic v);
      @(negedge clk);
      cfg_we   = 1'b1;
      cfg_page = pg;
      cfg_prot = v;
      @(negedge clk);
      cfg_we   = 1'b0;
   endtask

   // memory model: answers each line transfer two cycles after it appears
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req) begin
            repeat (2) @(negedge clk);
            if (mem_we) begin
               for (int w = 0; w < 4; w++) bmem[int'(mem_addr[11:2]) + w] = mem_wline[w*32 +: 32];
               nwb++;
            end else begin
               for (int w = 0; w < 4; w++) mem_rline[w*32 +: 32] = bmem[int'(mem_addr[11:2]) + w];
               nfill++;
            end
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic        err;
      int          lat;
      int          f0, w0;
      for (int i = 0; i < 1024; i++) begin
         bmem[i] = 32'hC0DE0000 | (i << 2);
         gmem[i] = bmem[i];
      end
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 ready", 64'(cpu_req_ready), 64'd1);
      check("R1 resp_valid", 64'(cpu_resp_valid), 64'd0);
      check("R1 mem_req", 64'(mem_req), 64'd0);

      cfg_write(6'd1, 1'b1);   // R5 page 1 protected while idle

      for (int n = 0; n < 13; n++) begin
         f0 = nfill;
         w0 = nwb;
         access(VEC[n][52], VEC[n][51:36], VEC[n][35:4], rd, err, lat);
         if (!VEC[n][52]) begin
            check($sformatf("R2/R3 data step %0d", n), 64'(rd), 64'(gmem[VEC[n][47:38]]));
            check($sformatf("R7 no error step %0d", n), 64'(err), 64'd0);
         end
         check($sformatf("R4 line reads step %0d", n), 64'(nfill - f0), 64'(VEC[n][3:2]));
         check($sformatf("R4 line writes step %0d", n), 64'(nwb - w0), 64'(VEC[n][1:0]));
      end

      // R2 unprotected hit latency
      access(1'b0, 16'h0014, 32'h0, rd, err, lat);
      check("R2 hit latency", 64'(lat), 64'd1);
      // R5 protected hit latency
      access(1'b0, 16'h0404, 32'h0, rd, err, lat);
      check("R5 hit latency", 64'(lat), 64'd2);
      check("R5 data", 64'(rd), 64'h00000000DEADBEEF);
      // R4 memory captured the dirty protected victim
      check("R4 victim in memory", 64'(bmem[10'h101]), 64'h00000000DEADBEEF);

      // R9 configuration write during a miss is ignored
      fork
         access(1'b0, 16'h0A00, 32'h0, rd, err, lat);
         begin
            repeat (2) @(negedge clk);
            cfg_we   = 1'b1;
            cfg_page = 6'd2;
            cfg_prot = 1'b1;
            @(negedge clk);
            cfg_we   = 1'b0;
         end
      join
      access(1'b0, 16'h0840, 32'h0, rd, err, lat);
      access(1'b0, 16'h0940, 32'h0, rd, err, lat);
      f0 = nfill;
      access(1'b0, 16'h0840, 32'h0, rd, err, lat);
      check("R9 page stays unprotected", 64'(nfill - f0), 64'd0);
      check("R9 latency", 64'(lat), 64'd1);

      // R7 single data-bit flip
      fcw = tb_enc(32'hDEADBEEF) ^ (39'd1 << 5);
      force u0.pcw_raw = fcw;
      access(1'b0, 16'h0404, 32'h0, rd, err, lat);
      release u0.pcw_raw;
      check("R7 data bit corrected", 64'(rd), 64'h00000000DEADBEEF);
      check("R7 no flag", 64'(err), 64'd0);
      // R7 single check-bit flip
      fcw = tb_enc(32'hDEADBEEF) ^ (39'd1 << 34);
      force u0.pcw_raw = fcw;
      access(1'b0, 16'h0404, 32'h0, rd, err, lat);
      release u0.pcw_raw;
      check("R7 check bit flip", 64'(rd), 64'h00000000DEADBEEF);
      check("R7 check bit no flag", 64'(err), 64'd0);
      // R8 double flip
      fcw = tb_enc(32'hDEADBEEF) ^ (39'd1 << 5) ^ (39'd1 << 20);
      force u0.pcw_raw = fcw;
      access(1'b0, 16'h0404, 32'h0, rd, err, lat);
      release u0.pcw_raw;
      check("R8 uncorrectable flag", 64'(err), 64'd1);
      // R8 clean read afterwards
      access(1'b0, 16'h0404, 32'h0, rd, err, lat);
      check("R8 clean after", 64'({err, rd}), 64'h00000000DEADBEEF);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule